// File: doc/BRIEF.md
# UART-Mimic Status Pacing Timers

This block paces the two status flags that a host sees when a local embedded processor imitates a UART through a mailbox. Real hardware needs one character time to move a byte. This block does not move data. It only delays the flags. One flag is "transmit holding empty" (`thre`). The other is "receive data ready" (`dr`). Each has its own single-pass down-counter. The delay is set in time-constant registers.

When the local processor takes the byte the host wrote, `thre` returns after the transmit delay. When the local processor deposits a byte for the host, `dr` rises after the receive delay. Each counter only steps on cycles where the `tick` enable is high. A system prescaler drives `tick`, so one tick stands for a bit time or a character time. A control bit per channel turns the delay off, and the flag is then set at once. Host accesses clear the flags.

Top module: `uart_status_pacer`

## Requirements
- R1: After reset, `thre` is 1, `dr` is 0, and register addresses 0, 1, 2 and 3 all read 0x00.
- R2: The register bus writes on a clock edge with `reg_we` high. The read data `reg_rdata` is combinational from `reg_addr`. Address 0 is control, with bit 7 enabling the transmit delay, bit 6 enabling the receive delay, and bits 2..0 as plain storage. Address 1 is the transmit time constant. Address 2 is the receive time constant. Address 3 reads 0.
- R3: Control bits 5..3 always read 0, whatever value was written.
- R4: Take this case: transmit delay enabled, a nonzero time constant N, and `cpu_tx_take` high at an edge. At that edge the transmit counter loads N and `thre` goes to 0. `thre` becomes 1 at the edge that samples the N-th tick after the load. With N = 0, `thre` is 1 at the take edge.
- R5: With the transmit delay disabled, `cpu_tx_take` sets `thre` to 1 at that edge and stops any running transmit count.
- R6: Take this case: receive delay enabled, a nonzero time constant N, and `cpu_rx_put` high at an edge. At that edge the receive counter loads N and `dr` goes to 0. `dr` becomes 1 at the edge that samples the N-th tick after the load. With N = 0, `dr` is 1 at the put edge.
- R7: With the receive delay disabled, `cpu_rx_put` sets `dr` to 1 at that edge and stops any running receive count.
- R8: A counter decrements only on cycles with `tick` high. It stops at zero and never reloads by itself. After expiry, further ticks leave the flag unchanged.
- R9: A qualifying access while a count is running reloads the counter from its time constant and restarts the full delay.
- R10: `host_tx_write` clears `thre` and `host_rx_read` clears `dr`. When a set of a flag falls in the same cycle as its clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_tx_take | input | 1 | Local processor took the transmit byte |
| cpu_rx_put | input | 1 | Local processor placed a receive byte |
| host_tx_write | input | 1 | Host wrote the transmit holding register |
| host_rx_read | input | 1 | Host read the receive buffer |
| tick | input | 1 | Single-cycle count enable |
| thre | output | 1 | Transmit holding empty flag |
| dr | output | 1 | Receive data ready flag |

## Verification
Register reads have zero latency. The bench checks `reg_rdata` one time step after it drives `reg_addr`, in the same cycle.

Access strobes, host clears and the final tick all act at the clock edge that samples them. The bench drives each stimulus just after a rising edge and checks the flag just after the next rising edge. It never samples at the edge itself.

In the vector walk, each tick is followed by an idle cycle. A flag that rose one tick early would therefore show up in a checked cycle, and so would a flag that counted idle cycles.

// File: rtl/uart_status_pacer.sv
module uart_status_pacer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_tx_take,
  input  logic              cpu_rx_put,
  input  logic              host_tx_write,
  input  logic              host_rx_read,
  input  logic              tick,
  output logic              thre,
  output logic              dr
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(8'hC7);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] ctrl_q, tx_tc, rx_tc, tx_cnt, rx_cnt;
  logic tx_en, rx_en, tx_arm, rx_arm, tx_expire, rx_expire;

  assign tx_en = ctrl_q[7];
  assign rx_en = ctrl_q[6];
  assign tx_arm = tx_en && (tx_tc != '0);
  assign rx_arm = rx_en && (rx_tc != '0);
  assign tx_expire = tick && (tx_cnt == ONE);
  assign rx_expire = tick && (rx_cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_tc  <= '0;
      rx_tc  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: ctrl_q <= reg_wdata & CTRL_MASK;
        2'd1: tx_tc  <= reg_wdata;
        2'd2: rx_tc  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = tx_tc;
      2'd2:    reg_rdata = rx_tc;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      thre   <= 1'b1;
    end else begin
      if (cpu_tx_take)                 tx_cnt <= tx_arm ? tx_tc : '0;
      else if (tick && tx_cnt != '0)   tx_cnt <= tx_cnt - ONE;

      if (cpu_tx_take)                 thre <= !tx_arm;
      else if (tx_expire)              thre <= 1'b1;
      else if (host_tx_write)          thre <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= '0;
      dr     <= 1'b0;
    end else begin
      if (cpu_rx_put)                  rx_cnt <= rx_arm ? rx_tc : '0;
      else if (tick && rx_cnt != '0)   rx_cnt <= rx_cnt - ONE;

      if (cpu_rx_put)                  dr <= !rx_arm;
      else if (rx_expire)              dr <= 1'b1;
      else if (host_rx_read)           dr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_status_pacer_checker.sv
module uart_status_pacer_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_tx_take,
  input logic              cpu_rx_put,
  input logic              tick,
  input logic              tx_en,
  input logic              rx_en,
  input logic [DATA_W-1:0] tx_tc,
  input logic [DATA_W-1:0] rx_tc,
  input logic [DATA_W-1:0] tx_cnt,
  input logic [DATA_W-1:0] rx_cnt,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              thre,
  input logic              dr
);
  assert_tx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tx_take && tx_en |=> tx_cnt == $past(tx_tc));
  assert_rx_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rx_put && rx_en |=> rx_cnt == $past(rx_tc));
  assert_tx_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tx_take && !tx_en |=> thre && tx_cnt == '0);
  assert_rx_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rx_put && !rx_en |=> dr && rx_cnt == '0);
  assert_thre_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt != '0 |-> !thre);
  assert_dr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt != '0 |-> !dr);
  assert_tx_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tx_take && !tick |=> $stable(tx_cnt));
  assert_rx_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rx_put && !tick |=> $stable(rx_cnt));
  assert_tx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_tx_take && tick && tx_cnt != '0 |=> tx_cnt == DATA_W'($past(tx_cnt) - 1'b1));

  always_comb begin
    if (rst_n && reg_addr == 2'd0)
      assert_reserved_zero_R3: assert (reg_rdata[5:3] == 3'b000);
  end
endmodule

bind uart_status_pacer uart_status_pacer_checker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .cpu_tx_take(cpu_tx_take), .cpu_rx_put(cpu_rx_put),
  .tick(tick), .tx_en(tx_en), .rx_en(rx_en), .tx_tc(tx_tc), .rx_tc(rx_tc),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .thre(thre), .dr(dr)
);

// File: tb/sim_uart_status_pacer.sv
`timescale 1ns/1ps
module sim_uart_status_pacer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cpu_tx_take = 0, cpu_rx_put = 0, host_tx_write = 0, host_rx_read = 0, tick = 0;
  logic thre, dr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  uart_status_pacer u0 (.clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
    .cpu_tx_take, .cpu_rx_put, .host_tx_write, .host_rx_read, .tick, .thre, .dr);

  // {time constant[17:10], enable[9], ticks[8:1], expected flag[0]}
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {8'd5,   1'b1, 8'd4,   1'b0},
    {8'd5,   1'b1, 8'd5,   1'b1},
    {8'd1,   1'b1, 8'd0,   1'b0},
    {8'd1,   1'b1, 8'd1,   1'b1},
    {8'd0,   1'b1, 8'd0,   1'b1},
    {8'd200, 1'b1, 8'd199, 1'b0},
    {8'd255, 1'b1, 8'd255, 1'b1},
    {8'd9,   1'b0, 8'd0,   1'b1},
    {8'd3,   1'b1, 8'd10,  1'b1}
  };

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; step(); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a; #1; check(reg_rdata, exp, req);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; step(); end
  endtask

  task automatic access(input int ch);
    if (ch == 0) cpu_tx_take = 1; else cpu_rx_put = 1;
    step(); cpu_tx_take = 0; cpu_rx_put = 0;
  endtask

  task automatic host_clear(input int ch);
    if (ch == 0) host_tx_write = 1; else host_rx_read = 1;
    step(); host_tx_write = 0; host_rx_read = 0;
  endtask

  function automatic logic flag(input int ch); return ch == 0 ? thre : dr; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    check(thre, 1, "R1 thre"); check(dr, 0, "R1 dr");
    for (int a = 0; a < 4; a++) rd(a[1:0], 8'h00, "R1 regs");

    wr(2'd0, 8'hFF); rd(2'd0, 8'hC7, "R3 reserved bits");
    wr(2'd1, 8'h5A); rd(2'd1, 8'h5A, "R2 tx constant");
    wr(2'd2, 8'hA5); rd(2'd2, 8'hA5, "R2 rx constant");
    wr(2'd3, 8'hFF); rd(2'd3, 8'h00, "R2 addr3");
    wr(2'd0, 8'h05); rd(2'd0, 8'h05, "R2 control");

    // vector walk: R4/R5 on transmit, R6/R7 on receive
    for (int ch = 0; ch < 2; ch++)
      for (int v = 0; v < NV; v++) begin
        wr(2'd0, VEC[v][9] ? (ch == 0 ? 8'h80 : 8'h40) : 8'h00);
        wr(ch == 0 ? 2'd1 : 2'd2, VEC[v][17:10]);
        host_clear(ch);
        check(flag(ch), 0, "R10 host clear");
        access(ch);
        ticks(int'(VEC[v][8:1]));
        check(flag(ch), VEC[v][0], ch == 0 ? (VEC[v][9] ? "R4 tx delay" : "R5 tx bypass")
                                           : (VEC[v][9] ? "R6 rx delay" : "R7 rx bypass"));
      end

    // R8: no tick, no progress; expiry stays; no reload
    wr(2'd0, 8'hC0); wr(2'd1, 8'd2); wr(2'd2, 8'd2);
    host_clear(0); access(0);
    repeat (20) step();
    check(thre, 0, "R8 idle cycles do not count");
    ticks(2); check(thre, 1, "R8 expiry");
    ticks(5); check(thre, 1, "R8 stays after expiry");
    host_clear(0); ticks(5); check(thre, 0, "R8 no auto reload");

    // R9: retrigger restarts the full delay
    wr(2'd1, 8'd4); access(0); ticks(3); access(0); ticks(3);
    check(thre, 0, "R9 tx restart");
    ticks(1); check(thre, 1, "R9 tx after full delay");
    wr(2'd2, 8'd4); access(1); ticks(3); access(1); ticks(3);
    check(dr, 0, "R9 rx restart");
    ticks(1); check(dr, 1, "R9 rx after full delay");

    // R5/R7: disable cancels a running count
    wr(2'd1, 8'd6); wr(2'd2, 8'd6); access(0); access(1);
    wr(2'd0, 8'h00); access(0); access(1);
    check(thre, 1, "R5 cancel"); check(dr, 1, "R7 cancel");
    host_clear(0); host_clear(1); ticks(8);
    check(thre, 0, "R5 no late set"); check(dr, 0, "R7 no late set");

    // R10: set wins over clear in the same cycle
    cpu_tx_take = 1; host_tx_write = 1; cpu_rx_put = 1; host_rx_read = 1; step();
    cpu_tx_take = 0; host_tx_write = 0; cpu_rx_put = 0; host_rx_read = 0;
    check(thre, 1, "R10 tx set wins"); check(dr, 1, "R10 rx set wins");
    wr(2'd0, 8'hC0); wr(2'd1, 8'd1); host_clear(0); access(0);
    tick = 1; host_tx_write = 1; step(); tick = 0; host_tx_write = 0;
    check(thre, 1, "R10 expiry wins");

    // R1: reset mid-count
    access(1); rst_n = 0; step(); rst_n = 1; step();
    check(thre, 1, "R1 thre after reset"); check(dr, 0, "R1 dr after reset");
    rd(2'd0, 8'h00, "R1 control after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule